// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns one software store into a control action aimed at a single processor. The stored word carries a two-bit command kind, a target processor number and a six-bit vector. The command kind picks one of four actions: post an interrupt with the vector, reset the processor and start it, park it in an idle state, or start it again.

The target number is checked against the number of processors the block is built for. Each processor has its own set of registered controls:
- an interrupt strobe, with one shared vector bus;
- a reset strobe;
- an activate strobe;
- a halt level, which the block keeps.

Each strobe lasts one clock. The outputs change on the clock edge that samples the store, so they are visible one cycle after the store is presented. A reset command is acted on only when its vector equals the power-on-reset code, which is a build parameter. Any other vector discards the command and raises a sticky error flag.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset every halt bit is 0 (running), every strobe is 0, the error flag is 0 and the vector bus is 0.
- R2: A store with kind 0 (bits 17:16 = 0) raises intr_post only for the processor in bits 12:8, for exactly the next cycle, with intr_vec equal to bits 5:0.
- R3: A store with kind 1 and vector equal to POR_VEC raises cpu_reset and cpu_activate together for the target in the next cycle, and clears its halt bit.
- R4: A store with kind 1 and any other vector raises no strobe, leaves every halt bit unchanged and sets the error flag.
- R5: Once set, the error flag stays set until the block is reset.
- R6: A store with kind 2 sets the target's halt bit. An interrupt posted later to a halted processor still strobes intr_post but leaves the halt bit set.
- R7: A store with kind 3 clears the target's halt bit and strobes cpu_activate for one cycle.
- R8: A store whose target number is not below NUM_CPUS changes no output. This includes the error flag, even for a reset store with a wrong vector.
- R9: A cycle without a store drives every strobe low. Halt bits and the error flag keep their values.
- R10: Bits of the store outside 17:16, 12:8 and 5:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Dispatch store strobe |
| wr_data | input | DATA_W | Store word: kind, target, vector |
| intr_post | output | NUM_CPUS | One-cycle interrupt strobe per processor |
| intr_vec | output | VEC_W | Vector of the most recent posted interrupt |
| cpu_reset | output | NUM_CPUS | One-cycle power-on-reset strobe per processor |
| cpu_activate | output | NUM_CPUS | One-cycle start strobe per processor |
| cpu_halt | output | NUM_CPUS | Idle level per processor, 1 = parked |
| bad_reset_err | output | 1 | Sticky flag for a reset store with a wrong vector |

## Verification
The hardest case to reach is a reset store that combines a bad vector with a target number above the built processor count. That store must leave the error flag clear. The stimulus therefore sends it first, before any in-range bad reset has set the sticky flag, so that a wrong error would be visible.

A second hard case is an interrupt to a processor that was parked earlier. The halt level must survive that interrupt. The stimulus parks processor 5, posts an interrupt to it, and only then resumes it, checking the halt vector after each step.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int KIND_LO = 16;
  localparam int CPU_LO  = 8;
  localparam int VEC_LO  = 0;
  localparam int KIND_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    K_INTR   = 2'd0,
    K_RESET  = 2'd1,
    K_IDLE   = 2'd2,
    K_RESUME = 2'd3
  } kind_e;

  typedef struct packed {
    logic do_intr;
    logic do_reset;
    logic do_idle;
    logic do_resume;
  } act_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CPUS = 8,
  parameter int CPU_W    = 5,
  parameter int VEC_W    = 6,
  parameter int POR_VEC  = 1
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CPUS-1:0] tgt_sel,
  output act_t              act,
  output logic              bad_reset,
  output logic [VEC_W-1:0]  vec
);
  kind_e            kind;
  logic [CPU_W-1:0] cpu;
  logic             in_range;

  always_comb begin
    kind     = kind_e'(wr_data[KIND_LO +: KIND_W]);
    cpu      = wr_data[CPU_LO +: CPU_W];
    vec      = wr_data[VEC_LO +: VEC_W];
    in_range = wr_en && (int'(cpu) < NUM_CPUS);
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_sel
    assign tgt_sel[i] = in_range && (cpu == CPU_W'(i));
  end

  always_comb begin
    act       = '0;
    bad_reset = 1'b0;
    if (in_range) begin
      unique case (kind)
        K_INTR:   act.do_intr = 1'b1;
        K_RESET:  begin
          if (vec == VEC_W'(POR_VEC)) act.do_reset = 1'b1;
          else                        bad_reset    = 1'b1;
        end
        K_IDLE:   act.do_idle   = 1'b1;
        K_RESUME: act.do_resume = 1'b1;
        default:  act = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cpu_ctrl.sv
module ipi_cpu_ctrl
  import ipi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  act_t act,
  output logic post_q,
  output logic reset_q,
  output logic activate_q,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      post_q     <= 1'b0;
      reset_q    <= 1'b0;
      activate_q <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      post_q     <= sel && act.do_intr;
      reset_q    <= sel && act.do_reset;
      activate_q <= sel && (act.do_reset || act.do_resume);
      if (sel && act.do_idle)
        halt_q <= 1'b1;
      else if (sel && (act.do_reset || act.do_resume))
        halt_q <= 1'b0;
    end
  end

  AST_RESET_STARTS: assert property (@(posedge clk) disable iff (rst)
    reset_q |-> (activate_q && !halt_q)); // R3
  AST_INTR_KEEPS_HALT: assert property (@(posedge clk) disable iff (rst)
    (halt_q && sel && act.do_intr) |=> halt_q); // R6
endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CPUS = 8,
  parameter int CPU_W    = 5,
  parameter int VEC_W    = 6,
  parameter int POR_VEC  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_CPUS-1:0] intr_post,
  output logic [VEC_W-1:0]    intr_vec,
  output logic [NUM_CPUS-1:0] cpu_reset,
  output logic [NUM_CPUS-1:0] cpu_activate,
  output logic [NUM_CPUS-1:0] cpu_halt,
  output logic                bad_reset_err
);
  logic [NUM_CPUS-1:0] tgt_sel;
  act_t                act;
  logic                bad_reset;
  logic [VEC_W-1:0]    vec;

  ipi_decode #(
    .DATA_W(DATA_W), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
    .VEC_W(VEC_W), .POR_VEC(POR_VEC)
  ) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .tgt_sel(tgt_sel),
    .act(act), .bad_reset(bad_reset), .vec(vec)
  );

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    ipi_cpu_ctrl u_ctrl (
      .clk(clk), .rst(rst), .sel(tgt_sel[i]), .act(act),
      .post_q(intr_post[i]), .reset_q(cpu_reset[i]),
      .activate_q(cpu_activate[i]), .halt_q(cpu_halt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_vec      <= '0;
      bad_reset_err <= 1'b0;
    end else begin
      if (act.do_intr) intr_vec <= vec;
      if (bad_reset)   bad_reset_err <= 1'b1;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(intr_post | cpu_reset | cpu_activate)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    bad_reset_err |=> bad_reset_err); // R5
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (intr_post == '0 && cpu_reset == '0 && cpu_activate == '0)); // R9
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_data[CPU_LO +: CPU_W]) >= NUM_CPUS)
      |=> (intr_post == '0 && cpu_reset == '0 && cpu_activate == '0
           && $stable(cpu_halt) && $stable(bad_reset_err))); // R8
  AST_BAD_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[KIND_LO +: KIND_W] == 2'd1
     && int'(wr_data[CPU_LO +: CPU_W]) < NUM_CPUS
     && wr_data[VEC_LO +: VEC_W] != VEC_W'(POR_VEC))
      |=> (bad_reset_err && cpu_reset == '0 && $stable(cpu_halt))); // R4
endmodule

// File: tb/ipi_cmd_dispatch_tb.sv
module ipi_cmd_dispatch_tb_top;
  localparam int N  = 8;
  localparam int VW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] intr_post, cpu_reset, cpu_activate, cpu_halt;
  logic [VW-1:0] intr_vec;
  logic bad_reset_err;

  always #2 clk = ~clk;

  ipi_cmd_dispatch #(.NUM_CPUS(N), .POR_VEC(1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .intr_post(intr_post), .intr_vec(intr_vec), .cpu_reset(cpu_reset),
    .cpu_activate(cpu_activate), .cpu_halt(cpu_halt),
    .bad_reset_err(bad_reset_err)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] post, rstp, act, halt;
    logic [VW-1:0] vec;
    logic         err;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [N-1:0] m_halt = '0;
  logic m_err = 1'b0;
  bit done = 0;

  function automatic logic [31:0] cmd(input int kind, input int cpu, input int vec);
    return (32'(kind) << 16) | (32'(cpu & 31) << 8) | 32'(vec & 63);
  endfunction

  task automatic drive(input logic we, input logic [31:0] d, input string tag);
    exp_t e;
    int k, c, v;
    @(negedge clk);
    wr_en = we;
    wr_data = d;
    k = int'(d[17:16]); c = int'(d[12:8]); v = int'(d[5:0]);
    e.tag = tag; e.post = '0; e.rstp = '0; e.act = '0; e.vec = VW'(v);
    if (we && c < N) begin
      case (k)
        0: e.post[c] = 1'b1;
        1: if (v == 1) begin e.rstp[c] = 1'b1; e.act[c] = 1'b1; m_halt[c] = 1'b0; end
           else m_err = 1'b1;
        2: m_halt[c] = 1'b1;
        default: begin e.act[c] = 1'b1; m_halt[c] = 1'b0; end
      endcase
    end
    e.halt = m_halt;
    e.err  = m_err;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (intr_post !== e.post || cpu_reset !== e.rstp || cpu_activate !== e.act ||
            cpu_halt !== e.halt || bad_reset_err !== e.err ||
            (e.post != '0 && intr_vec !== e.vec)) begin
          fails++;
          $display("FAIL %s: actual post=%b rst=%b act=%b halt=%b err=%b vec=%0d expected post=%b rst=%b act=%b halt=%b err=%b vec=%0d",
                   e.tag, intr_post, cpu_reset, cpu_activate, cpu_halt, bad_reset_err,
                   intr_vec, e.post, e.rstp, e.act, e.halt, e.err, e.vec);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (cpu_halt !== '0 || intr_post !== '0 || cpu_reset !== '0 ||
        cpu_activate !== '0 || bad_reset_err !== 1'b0 || intr_vec !== '0) begin
      fails++;
      $display("FAIL R1: actual halt=%b post=%b rst=%b act=%b err=%b vec=%0d expected all zero",
               cpu_halt, intr_post, cpu_reset, cpu_activate, bad_reset_err, intr_vec);
    end
    drive(1, cmd(0, 3, 42), "R2 intr cpu3");
    drive(0, '0, "R9 idle after intr");
    drive(1, cmd(0, 0, 63), "R2 intr cpu0");
    drive(1, cmd(0, 7, 5), "R2 intr cpu7 back-to-back");
    drive(1, cmd(1, 31, 7), "R8 bad reset out of range, no err");
    drive(1, cmd(0, 8, 9), "R8 intr cpu8 out of range");
    drive(1, cmd(2, 12, 0), "R8 idle cpu12 out of range");
    drive(1, cmd(2, 5, 0), "R6 idle cpu5");
    drive(1, cmd(0, 5, 17), "R6 intr to halted cpu5");
    drive(0, '0, "R9 halt held");
    drive(1, cmd(3, 5, 0), "R7 resume cpu5");
    drive(1, cmd(2, 2, 0), "R6 idle cpu2");
    drive(1, cmd(1, 2, 1), "R3 por reset cpu2");
    drive(1, cmd(2, 6, 0), "R6 idle cpu6");
    drive(1, cmd(1, 6, 5), "R4 bad reset cpu6");
    drive(0, '0, "R5 err sticky");
    drive(1, cmd(0, 1, 3), "R5 err sticky after intr");
    drive(1, 32'hFFFC_E0C0 | cmd(0, 4, 11), "R10 junk bits intr cpu4");
    drive(1, 32'hFFFC_E0C0 | cmd(3, 6, 0), "R10 junk bits resume cpu6");
    drive(0, '0, "R9 final idle");
    drive(0, '0, "R9 final idle 2");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule